// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block owns the program counter, the stack pointer and the processor status byte of a small 8-bit accumulator processor. After the decoder has read an instruction and its operand bytes, it hands the block a 4-bit operation code, up to two operand bytes, the address of the next instruction and the live status flags. The block then works out the next program counter. Some operations need the stack or a pointer in memory. For those it runs a short multi-cycle sequence over a byte-wide memory port whose read data is registered.

Branches and the absolute jump finish in a single cycle. Calls, returns, the indirect jump, the interrupt return and the two flag-stack operations read or write memory one byte at a time. The stack sits in a fixed page, and the stack pointer selects the byte within that page. A `done` pulse marks the cycle in which `pc_out`, `sp_out` and `flags_out` hold the new result. `busy` is high while a sequence is in flight.

Top module: `pcsu_top`

## Requirements
- R1: After reset `pc_out` is 0x0000, `sp_out` is 0xFF, `flags_out` is 0x00, and `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: Operation codes 0 to 7 are conditional branches. Bits [2:1] choose the tested flag: 00 selects carry (flag bit 0), 01 zero (bit 1), 10 overflow (bit 6) and 11 negative (bit 7). The branch is taken when that flag equals op bit 0. A taken branch loads `pc_in` plus the sign-extended `opnd_lo`. A branch that is not taken loads `pc_in`. Code 15 is a no-operation that also loads `pc_in`.
- R3: The branch target addition wraps modulo 2^16.
- R4: Code 8 (absolute jump) loads `{opnd_hi, opnd_lo}`.
- R5: Code 9 (indirect jump) reads the low byte at pointer P = `{opnd_hi, opnd_lo}` and the high byte at P+1, then loads `{high, low}`.
- R6: When the pointer low byte is 0xFF, the indirect jump reads its high byte at offset 0x00 of the same page, not from the next page.
- R7: Code 10 (call) computes R = `pc_in` - 1. It writes R[15:8] at 0x0100+SP and R[7:0] at 0x0100+SP-1, lowers SP by two and loads `{opnd_hi, opnd_lo}`.
- R8: Code 11 (return) raises SP by one and reads the low byte, then raises SP by one and reads the high byte. It loads `{high, low}` + 1.
- R9: Code 13 (flag push) writes `flags_in` at 0x0100+SP, lowers SP by one and leaves `pc_out` unchanged.
- R10: Code 14 (flag pull) raises SP by one, loads `flags_out` from 0x0100+SP with a one-cycle `flags_we` pulse, and leaves `pc_out` unchanged.
- R11: Code 12 (interrupt return) pulls the flags first, then the low byte, then the high byte. It loads `{high, low}` with no increment and raises SP by three.
- R12: The stack pointer wraps within its page: pushing at SP 0x00 leaves 0xFF, and pulling at SP 0xFF reads address 0x0100.
- R13: `done` rises exactly N cycles after the cycle in which `start` is sampled. N is 1 for branches, the no-operation and the jump, 2 for the flag push, 3 for call and flag pull, 5 for return and indirect jump, and 7 for interrupt return. `busy` is high in between, and `start` is ignored while `busy` is high. `pc_out` and `flags_out` change only together with `done` and `flags_we` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op | input | 4 | Operation code (see R2 to R11) |
| opnd_lo | input | 8 | First operand byte: displacement or target/pointer low byte |
| opnd_hi | input | 8 | Second operand byte: target/pointer high byte |
| pc_in | input | 16 | Address of the instruction after the current one |
| flags_in | input | 8 | Current status flags |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | A multi-cycle operation is in flight |
| done | output | 1 | One-cycle pulse: the results are valid |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer (offset within the stack page) |
| flags_out | output | 8 | Status flags as restored from the stack |
| flags_we | output | 1 | Pulse marking a new `flags_out` value |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read request |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |

## Verification
Every memory read costs two cycles: one with the request on the port and one with the data back. A return or indirect jump therefore completes five cycles after `start` is sampled, and an interrupt return seven. Branches and the jump complete on the next cycle, the flag push on the second, and call and flag pull on the third. The driver records the cycle in which it raised `start` and pushes the expected program counter, stack pointer, flags and latency into a queue. The monitor samples on the falling edge, pops an entry on each `done` and compares both the values and the elapsed cycle count. Stack memory contents are checked only after `done`, because the final write lands on that same edge.

// File: rtl/pcsu_pkg.sv
package pcsu_pkg;

    localparam int PCSU_AW = 16;
    localparam int PCSU_DW = 8;

    typedef enum logic [3:0] {
        OP_BCC   = 4'd0,
        OP_BCS   = 4'd1,
        OP_BNE   = 4'd2,
        OP_BEQ   = 4'd3,
        OP_BVC   = 4'd4,
        OP_BVS   = 4'd5,
        OP_BPL   = 4'd6,
        OP_BMI   = 4'd7,
        OP_JMP   = 4'd8,
        OP_JMPI  = 4'd9,
        OP_CALL  = 4'd10,
        OP_RET   = 4'd11,
        OP_RTI   = 4'd12,
        OP_PUSHF = 4'd13,
        OP_PULLF = 4'd14,
        OP_NOP   = 4'd15
    } pcsu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH2,
        ST_WFIN,
        ST_RD_FL,
        ST_RD_LO,
        ST_RD_HI
    } pcsu_st_e;

    typedef struct packed {
        pcsu_st_e            st;
        logic                ph;
        pcsu_op_e            op;
        logic [PCSU_AW-1:0]  pc;
        logic [PCSU_DW-1:0]  sp;
        logic [PCSU_DW-1:0]  flags;
        logic                flags_we;
        logic                done;
        logic [PCSU_AW-1:0]  tmp;
        logic [PCSU_DW-1:0]  lo;
        logic [PCSU_AW-1:0]  addr;
        logic                we;
        logic                re;
        logic [PCSU_DW-1:0]  wdata;
    } pcsu_regs_t;

endpackage

// File: rtl/pcsu_branch.sv
module pcsu_branch #(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int NCOND  = 4
) (
    input  logic [2:0]       op_lo,
    input  logic [NCOND-1:0] cond_flags,
    input  logic [AW-1:0]    pc_next,
    input  logic [DW-1:0]    disp,
    output logic             taken,
    output logic [AW-1:0]    target
);
    localparam int EXT = AW - DW;

    logic [NCOND-1:0] hit;

    // one comparator per testable flag; op bit 0 is the wanted polarity
    for (genvar i = 0; i < NCOND; i++) begin : g_cond
        assign hit[i] = (cond_flags[i] == op_lo[0]);
    end

    assign taken  = hit[op_lo[2:1]];
    assign target = pc_next + {{EXT{disp[DW-1]}}, disp};

endmodule

// File: rtl/pcsu_stack.sv
module pcsu_stack #(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  logic [DW-1:0]   sp,
    output logic [2*DW-1:0] push_addr,
    output logic [2*DW-1:0] pull_addr,
    output logic [DW-1:0]   sp_dec,
    output logic [DW-1:0]   sp_inc
);
    assign sp_dec    = sp - 1'b1;
    assign sp_inc    = sp + 1'b1;
    assign push_addr = {STACK_PAGE, sp};
    assign pull_addr = {STACK_PAGE, sp_inc};
endmodule

// File: rtl/pcsu_page_inc.sv
module pcsu_page_inc #(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] ptr,
    output logic [2*DW-1:0] ptr_next
);
    // carry out of the low byte is dropped: the page never changes
    logic [DW-1:0] lo_next;
    assign lo_next  = ptr[DW-1:0] + 1'b1;
    assign ptr_next = {ptr[2*DW-1:DW], lo_next};
endmodule

// File: rtl/pcsu_top.sv
module pcsu_top
    import pcsu_pkg::*;
#(
    parameter logic [PCSU_DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [PCSU_DW-1:0] SP_RESET   = 8'hFF,
    parameter logic [PCSU_AW-1:0] PC_RESET   = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         op,
    input  logic [PCSU_DW-1:0] opnd_lo,
    input  logic [PCSU_DW-1:0] opnd_hi,
    input  logic [PCSU_AW-1:0] pc_in,
    input  logic [PCSU_DW-1:0] flags_in,
    input  logic [PCSU_DW-1:0] mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [PCSU_AW-1:0] pc_out,
    output logic [PCSU_DW-1:0] sp_out,
    output logic [PCSU_DW-1:0] flags_out,
    output logic               flags_we,
    output logic [PCSU_AW-1:0] mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [PCSU_DW-1:0] mem_wdata
);
    localparam int NCOND = 4;

    pcsu_regs_t q, d;

    // ---------------------------------------------------------------
    // helpers
    // ---------------------------------------------------------------
    logic [NCOND-1:0]   cond_flags;
    logic               br_taken;
    logic [PCSU_AW-1:0] br_target;
    logic [PCSU_AW-1:0] push_addr, pull_addr;
    logic [PCSU_DW-1:0] sp_dec, sp_inc;
    logic [PCSU_AW-1:0] ptr_next;
    logic [PCSU_AW-1:0] opnd_word;
    logic [PCSU_AW-1:0] ret_addr;
    logic [PCSU_AW-1:0] pulled_word;

    assign cond_flags  = {flags_in[7], flags_in[6], flags_in[1], flags_in[0]};
    assign opnd_word   = {opnd_hi, opnd_lo};
    assign ret_addr    = pc_in - 16'd1;
    assign pulled_word = {mem_rdata, q.lo};

    pcsu_branch #(
        .AW    (PCSU_AW),
        .DW    (PCSU_DW),
        .NCOND (NCOND)
    ) branch_i (
        .op_lo      (op[2:0]),
        .cond_flags (cond_flags),
        .pc_next    (pc_in),
        .disp       (opnd_lo),
        .taken      (br_taken),
        .target     (br_target)
    );

    pcsu_stack #(
        .DW         (PCSU_DW),
        .STACK_PAGE (STACK_PAGE)
    ) stack_i (
        .sp        (q.sp),
        .push_addr (push_addr),
        .pull_addr (pull_addr),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc)
    );

    pcsu_page_inc #(
        .DW (PCSU_DW)
    ) pinc_i (
        .ptr      (q.tmp),
        .ptr_next (ptr_next)
    );

    // ---------------------------------------------------------------
    // next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.flags_we = 1'b0;
        d.we       = 1'b0;
        d.re       = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op = pcsu_op_e'(op);
                    d.ph = 1'b0;
                    case (pcsu_op_e'(op))
                        OP_JMP: begin
                            d.pc   = opnd_word;
                            d.done = 1'b1;
                        end
                        OP_JMPI: begin
                            d.tmp  = opnd_word;
                            d.addr = opnd_word;
                            d.re   = 1'b1;
                            d.st   = ST_RD_LO;
                        end
                        OP_CALL: begin
                            d.tmp   = opnd_word;
                            d.lo    = ret_addr[PCSU_DW-1:0];
                            d.addr  = push_addr;
                            d.we    = 1'b1;
                            d.wdata = ret_addr[PCSU_AW-1:PCSU_DW];
                            d.sp    = sp_dec;
                            d.st    = ST_PUSH2;
                        end
                        OP_PUSHF: begin
                            d.addr  = push_addr;
                            d.we    = 1'b1;
                            d.wdata = flags_in;
                            d.sp    = sp_dec;
                            d.st    = ST_WFIN;
                        end
                        OP_PULLF, OP_RTI: begin
                            d.sp   = sp_inc;
                            d.addr = pull_addr;
                            d.re   = 1'b1;
                            d.st   = ST_RD_FL;
                        end
                        OP_RET: begin
                            d.sp   = sp_inc;
                            d.addr = pull_addr;
                            d.re   = 1'b1;
                            d.st   = ST_RD_LO;
                        end
                        OP_NOP: begin
                            d.pc   = pc_in;
                            d.done = 1'b1;
                        end
                        default: begin
                            d.pc   = br_taken ? br_target : pc_in;
                            d.done = 1'b1;
                        end
                    endcase
                end
            end

            ST_PUSH2: begin
                d.addr  = push_addr;
                d.we    = 1'b1;
                d.wdata = q.lo;
                d.sp    = sp_dec;
                d.st    = ST_WFIN;
            end

            ST_WFIN: begin
                if (q.op == OP_CALL) begin
                    d.pc = q.tmp;
                end
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end

            ST_RD_FL: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.flags    = mem_rdata;
                    d.flags_we = 1'b1;
                    d.ph       = 1'b0;
                    if (q.op == OP_PULLF) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.sp   = sp_inc;
                        d.addr = pull_addr;
                        d.re   = 1'b1;
                        d.st   = ST_RD_LO;
                    end
                end
            end

            ST_RD_LO: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.lo = mem_rdata;
                    d.ph = 1'b0;
                    d.re = 1'b1;
                    d.st = ST_RD_HI;
                    if (q.op == OP_JMPI) begin
                        d.addr = ptr_next;
                    end else begin
                        d.sp   = sp_inc;
                        d.addr = pull_addr;
                    end
                end
            end

            ST_RD_HI: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph   = 1'b0;
                    d.pc   = (q.op == OP_RET) ? pulled_word + 16'd1 : pulled_word;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.ph       <= 1'b0;
            q.op       <= OP_NOP;
            q.pc       <= PC_RESET;
            q.sp       <= SP_RESET;
            q.flags    <= '0;
            q.flags_we <= 1'b0;
            q.done     <= 1'b0;
            q.tmp      <= '0;
            q.lo       <= '0;
            q.addr     <= '0;
            q.we       <= 1'b0;
            q.re       <= 1'b0;
            q.wdata    <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign pc_out    = q.pc;
    assign sp_out    = q.sp;
    assign flags_out = q.flags;
    assign flags_we  = q.flags_we;
    assign mem_addr  = q.addr;
    assign mem_re    = q.re;
    assign mem_we    = q.we;
    assign mem_wdata = q.wdata;

endmodule

// File: rtl/pcsu_chk.sv
module pcsu_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        busy,
    input logic [15:0] pc_out,
    input logic [7:0]  flags_out,
    input logic        flags_we,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr
);
    // R7
    stack_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE));

    // R9
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R13
    pc_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_out) |-> done);

    // R10
    flags_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags_out) |-> flags_we);

    // R13
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pcsu_top pcsu_chk #(.STACK_PAGE(STACK_PAGE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .busy      (busy),
    .pc_out    (pc_out),
    .flags_out (flags_out),
    .flags_we  (flags_we),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr)
);

// File: tb/pcsu_top_tb_top.sv
`timescale 1ns/1ps
module pcsu_top_tb_top;

    typedef struct {
        logic [15:0] pc;
        logic [7:0]  sp;
        logic [7:0]  fl;
        int          lat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [7:0]  opnd_lo = 8'h00, opnd_hi = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  flags_in = 8'h00;
    logic [7:0]  mem_rdata;
    logic        busy, done, flags_we, mem_re, mem_we;
    logic [15:0] pc_out, mem_addr;
    logic [7:0]  sp_out, flags_out, mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int start_cyc = 0;
    exp_t sb[$];

    // bench memory, 1 KiB image indexed by address[9:0]
    logic [7:0] mem [0:1023];
    logic       poke_en = 1'b0;
    logic [9:0] poke_a = '0;
    logic [7:0] poke_d = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    pcsu_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .pc_in(pc_in),
        .flags_in(flags_in), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .flags_out(flags_out), .flags_we(flags_we), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // monitor: pops one expectation per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R13 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " pc"}, {16'h0, pc_out}, {16'h0, e.pc});
                chk({e.tag, " sp"}, {24'h0, sp_out}, {24'h0, e.sp});
                chk({e.tag, " flags"}, {24'h0, flags_out}, {24'h0, e.fl});
                chk({e.tag, " R13 latency"}, cyc - start_cyc - 1, e.lat);
            end
        end
    end

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a[9:0]; poke_d = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic issue(input logic [3:0] o, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] pci, input logic [7:0] fl,
                         input logic [15:0] epc, input logic [7:0] esp,
                         input logic [7:0] efl, input int lat, input string tag);
        exp_t e;
        e.pc = epc; e.sp = esp; e.fl = efl; e.lat = lat; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op = o; opnd_lo = lo; opnd_hi = hi; pc_in = pci; flags_in = fl;
        start = 1'b1; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    function automatic logic flag_of(input logic [2:0] o, input logic [7:0] fl);
        case (o[2:1])
            2'b00:   return fl[0];
            2'b01:   return fl[1];
            2'b10:   return fl[6];
            default: return fl[7];
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R13 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", {16'h0, pc_out}, 32'h0000);
        chk("R1 sp", {24'h0, sp_out}, 32'hFF);
        chk("R1 flags", {24'h0, flags_out}, 32'h00);
        chk("R1 busy/done", {30'h0, busy, done}, 32'h0);
        chk("R1 mem strobes", {30'h0, mem_we, mem_re}, 32'h0);

        // R2 all eight conditions, both flag polarities
        for (int o = 0; o < 8; o++) begin
            logic [15:0] e;
            e = (flag_of(o[2:0], 8'h00) == o[0]) ? 16'h1244 : 16'h1234;
            issue(o[3:0], 8'h10, 8'h00, 16'h1234, 8'h00, e, 8'hFF, 8'h00, 0, "R2 flags clear");
            e = (flag_of(o[2:0], 8'hC3) == o[0]) ? 16'h1214 : 16'h1234;
            issue(o[3:0], 8'hE0, 8'h00, 16'h1234, 8'hC3, e, 8'hFF, 8'h00, 0, "R2 flags set");
        end
        issue(4'd15, 8'h55, 8'h66, 16'h2222, 8'h00, 16'h2222, 8'hFF, 8'h00, 0, "R2 nop");
        // R3 wrap both directions
        issue(4'd0, 8'h20, 8'h00, 16'hFFF0, 8'h00, 16'h0010, 8'hFF, 8'h00, 0, "R3 forward wrap");
        issue(4'd1, 8'hF0, 8'h00, 16'h0005, 8'h01, 16'hFFF5, 8'hFF, 8'h00, 0, "R3 backward wrap");
        // R4
        issue(4'd8, 8'hEF, 8'hBE, 16'h0000, 8'h00, 16'hBEEF, 8'hFF, 8'h00, 0, "R4 jump");
        // R5
        poke(16'h0240, 8'h34); poke(16'h0241, 8'h12);
        issue(4'd9, 8'h40, 8'h02, 16'h0000, 8'h00, 16'h1234, 8'hFF, 8'h00, 4, "R5 indirect");
        // R6 page-boundary pointer
        poke(16'h02FF, 8'h78); poke(16'h0200, 8'h56); poke(16'h0300, 8'h99);
        issue(4'd9, 8'hFF, 8'h02, 16'h0000, 8'h00, 16'h5678, 8'hFF, 8'h00, 4, "R6 page wrap");
        // R7 call
        issue(4'd10, 8'h00, 8'h80, 16'h4003, 8'h00, 16'h8000, 8'hFD, 8'h00, 2, "R7 call");
        chk("R7 pushed high", {24'h0, mem[10'h1FF]}, 32'h40);
        chk("R7 pushed low", {24'h0, mem[10'h1FE]}, 32'h02);
        // R9 push flags
        issue(4'd13, 8'h00, 8'h00, 16'h1111, 8'hA5, 16'h8000, 8'hFC, 8'h00, 1, "R9 push flags");
        chk("R9 pushed byte", {24'h0, mem[10'h1FD]}, 32'hA5);
        // R10 pull flags
        issue(4'd14, 8'h00, 8'h00, 16'h1111, 8'h00, 16'h8000, 8'hFD, 8'hA5, 2, "R10 pull flags");
        // R8 return
        issue(4'd11, 8'h00, 8'h00, 16'h1111, 8'h00, 16'h4003, 8'hFF, 8'hA5, 4, "R8 return");
        // R11 + R12 pull wraps from 0xFF to 0x0100
        poke(16'h0100, 8'h3C); poke(16'h0101, 8'hCD); poke(16'h0102, 8'hAB);
        issue(4'd12, 8'h00, 8'h00, 16'h1111, 8'h00, 16'hABCD, 8'h02, 8'h3C, 6, "R11 R12 int return");
        // R12 push wraps from 0x00 to 0xFF
        issue(4'd13, 8'h00, 8'h00, 16'h0, 8'h11, 16'hABCD, 8'h01, 8'h3C, 1, "R12 push a");
        issue(4'd13, 8'h00, 8'h00, 16'h0, 8'h22, 16'hABCD, 8'h00, 8'h3C, 1, "R12 push b");
        issue(4'd13, 8'h00, 8'h00, 16'h0, 8'h33, 16'hABCD, 8'hFF, 8'h3C, 1, "R12 push c");
        chk("R12 byte at page base", {24'h0, mem[10'h100]}, 32'h33);

        // R13 start ignored while busy: return pulls 0x33, 0x22 -> 0x2234
        begin
            exp_t e;
            e.pc = 16'h2234; e.sp = 8'h01; e.fl = 8'h3C; e.lat = 4; e.tag = "R13 start while busy";
            sb.push_back(e);
            @(negedge clk);
            op = 4'd11; start = 1'b1; start_cyc = cyc;
            @(negedge clk);
            start = 1'b0;
            chk("R13 busy during sequence", {31'h0, busy}, 32'h1);
            @(negedge clk);
            op = 4'd8; opnd_lo = 8'hAD; opnd_hi = 8'hDE; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
            chk("R13 no second result", {16'h0, pc_out}, 32'h2234);
        end

        finish_run();
    end

endmodule